// File: doc/BRIEF.md
# Six-Entry Lap-Flag FIFO

This block is a single-clock first-in first-out queue that holds exactly six words. All six can be occupied at once, so no slot is kept empty to tell a full queue from an empty one. Each of the two pointers carries a slot index in its low bits and a lap flag in its top bit. A pointer steps through the six legal slot values and then jumps, so it never holds an illegal slot index. The slot index addresses the storage as it is, with no modulo or subtraction step on the access path.

A producer offers a word with `push_valid`, and the word is taken on a clock edge while `push_ready` is high. A consumer asks for a word with `pop_ready`. A pop is taken on a clock edge while `pop_valid` is high, and the word comes out on `pop_data` one cycle later, marked by `pop_data_valid`. The `full`, `empty` and `level` outputs report the fill state. If the depth parameter is set to a power of two, the pointers roll over in the plain binary way.

Top module: `lap_fifo`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `empty`=1, `full`=0, `level`=0 and `pop_data_valid`=0.
- R2: Each pointer steps through the values 0,1,2,3,4,5,8,9,10,11,12,13 and then back to 0. Bits [2:0] of a pointer never hold 6 or 7. Data order stays correct across any number of laps.
- R3: Six pushes with no pops fill all six slots: `level`=6 and `full`=1.
- R4: A push offered while `full`=1 is not taken. `push_ready` equals the inverse of `full`, and the stored contents do not change.
- R5: A pop requested while `empty`=1 is not taken. `pop_data_valid` stays 0 in the next cycle and the read pointer does not move.
- R6: Words leave in the order they were taken, with their values unchanged.
- R7: `level` (3 bits) ranges from 0 to 6. It rises by one for each push taken and falls by one for each pop taken.
- R8: `empty`=1 exactly when `level`=0. `full`=1 exactly when `level`=6. `pop_valid` equals the inverse of `empty`.
- R9: A push and a pop in the same cycle are both taken when each is allowed on its own, and `level` then stays the same. When the queue is full, only the pop is taken. When the queue is empty, only the push is taken.
- R10: `pop_data` is registered. It carries the popped word in the cycle after the pop is taken, and `pop_data_valid` is high in exactly that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| push_valid | input | 1 | Producer offers a word |
| push_ready | output | 1 | Queue can take a word |
| push_data | input | DATA_W | Word offered |
| pop_ready | input | 1 | Consumer requests a word |
| pop_valid | output | 1 | Queue holds at least one word |
| pop_data | output | DATA_W | Registered popped word |
| pop_data_valid | output | 1 | `pop_data` carries a fresh word this cycle |
| full | output | 1 | All slots occupied |
| empty | output | 1 | No slot occupied |
| level | output | CNT_W | Number of words held, 0 to DEPTH |

## Verification
The bench drives both ports at once while the queue is full and while it is empty. A design that let the push through when full would overwrite the oldest word. A design that let the pop through when empty would emit a stale word and push the read pointer past the write pointer. Long runs of steady traffic carry both pointers around many laps, through the 5-to-8 and 13-to-0 jumps. A wrong skip would put data in slots 6 or 7, and a wrong level formula would misreport the fill state once the lap flags differ. A reference queue checks every popped word and the one-cycle latency of `pop_data_valid`, which catches any reordering or any lost or repeated word.

// File: rtl/lap_fifo_pkg.sv
package lap_fifo_pkg;

  // Next pointer value: step within a lap, jump to the next lap after the last slot.
  function automatic int unsigned lap_next(input int unsigned p,
                                           input int unsigned depth,
                                           input int unsigned slot_w);
    int unsigned lo;
    int unsigned hi;
    lo = p & ((32'd1 << slot_w) - 1);
    hi = (p >> slot_w) & 32'd1;
    if (lo == depth - 1)
      return (hi != 0) ? 32'd0 : (32'd1 << slot_w);
    return p + 1;
  endfunction

  // Words held: slot difference, plus depth when the lap flags differ.
  function automatic int lap_level(input int unsigned wr,
                                   input int unsigned rd,
                                   input int unsigned depth,
                                   input int unsigned slot_w);
    int unsigned mask;
    int          lap_add;
    mask    = (32'd1 << slot_w) - 1;
    lap_add = (((wr >> slot_w) & 1) != ((rd >> slot_w) & 1)) ? int'(depth) : 0;
    return lap_add + int'(wr & mask) - int'(rd & mask);
  endfunction

endpackage

// File: rtl/lap_ptr.sv
module lap_ptr #(
  parameter int DEPTH  = 6,
  parameter int SLOT_W = 3,
  localparam int PTR_W = SLOT_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  output logic [PTR_W-1:0] ptr
);
  import lap_fifo_pkg::*;

  localparam bit POW2 = (DEPTH == (1 << SLOT_W));

  logic [PTR_W-1:0] ptr_nx;

  generate
    if (POW2) begin : g_roll
      assign ptr_nx = ptr + PTR_W'(1);
    end else begin : g_skip
      assign ptr_nx = PTR_W'(lap_next(32'(ptr), DEPTH, SLOT_W));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n)   ptr <= '0;
    else if (adv) ptr <= ptr_nx;
  end

  assert_slot_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
    32'(ptr[SLOT_W-1:0]) < DEPTH);

  assert_hold_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(ptr));

endmodule

// File: rtl/lap_store.sv
module lap_store #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 6,
  parameter int SLOT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [SLOT_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [SLOT_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= re;
      if (re) rdata <= mem[raddr];
    end
  end

  assert_read_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
    re |=> rvalid);

  assert_read_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !re |=> (!rvalid && $stable(rdata)));

endmodule

// File: rtl/lap_status.sv
module lap_status #(
  parameter int DEPTH  = 6,
  parameter int SLOT_W = 3,
  localparam int PTR_W = SLOT_W + 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PTR_W-1:0] wr_ptr,
  input  logic [PTR_W-1:0] rd_ptr,
  output logic             full,
  output logic             empty,
  output logic [CNT_W-1:0] level
);
  import lap_fifo_pkg::*;

  logic slot_same;
  logic lap_same;

  assign slot_same = (wr_ptr[SLOT_W-1:0] == rd_ptr[SLOT_W-1:0]);
  assign lap_same  = (wr_ptr[SLOT_W] == rd_ptr[SLOT_W]);
  assign empty     = slot_same && lap_same;
  assign full      = slot_same && !lap_same;
  assign level     = CNT_W'(lap_level(32'(wr_ptr), 32'(rd_ptr), DEPTH, SLOT_W));

  assert_level_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    32'(level) <= DEPTH);

  assert_flags_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({full, empty}));

  assert_empty_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
    empty == (level == '0));

  assert_full_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
    full == (32'(level) == DEPTH));

endmodule

// File: rtl/lap_fifo.sv
module lap_fifo #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 6,
  localparam int SLOT_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int PTR_W  = SLOT_W + 1,
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_valid,
  output logic              push_ready,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop_ready,
  output logic              pop_valid,
  output logic [DATA_W-1:0] pop_data,
  output logic              pop_data_valid,
  output logic              full,
  output logic              empty,
  output logic [CNT_W-1:0]  level
);
  logic [PTR_W-1:0] wr_ptr;
  logic [PTR_W-1:0] rd_ptr;
  logic             push_fire;
  logic             pop_fire;

  assign push_ready = !full;
  assign pop_valid  = !empty;
  assign push_fire  = push_valid && !full;
  assign pop_fire   = pop_ready && !empty;

  lap_ptr #(.DEPTH(DEPTH), .SLOT_W(SLOT_W)) u_wr_ptr (
    .clk(clk), .rst_n(rst_n), .adv(push_fire), .ptr(wr_ptr));

  lap_ptr #(.DEPTH(DEPTH), .SLOT_W(SLOT_W)) u_rd_ptr (
    .clk(clk), .rst_n(rst_n), .adv(pop_fire), .ptr(rd_ptr));

  lap_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .SLOT_W(SLOT_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .we(push_fire), .waddr(wr_ptr[SLOT_W-1:0]), .wdata(push_data),
    .re(pop_fire),  .raddr(rd_ptr[SLOT_W-1:0]),
    .rdata(pop_data), .rvalid(pop_data_valid));

  lap_status #(.DEPTH(DEPTH), .SLOT_W(SLOT_W)) u_status (
    .clk(clk), .rst_n(rst_n), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr),
    .full(full), .empty(empty), .level(level));

  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    full |=> $stable(wr_ptr));

  assert_no_underflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    empty |=> ($stable(rd_ptr) && !pop_data_valid));

  assert_level_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    int'(level) == int'($past(level)) + int'($past(push_fire)) - int'($past(pop_fire)));

  assert_both_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && pop_ready && !full && !empty) |=> $stable(level));

endmodule

// File: tb/lap_fifo_test.sv
module lap_fifo_test;
  localparam int DW = 8;
  localparam int DEPTH = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          push_valid = 1'b0;
  logic          push_ready;
  logic [DW-1:0] push_data = '0;
  logic          pop_ready = 1'b0;
  logic          pop_valid;
  logic [DW-1:0] pop_data;
  logic          pop_data_valid;
  logic          full;
  logic          empty;
  logic [2:0]    level;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  logic [DW-1:0] q[$];
  logic          exp_dv = 1'b0;
  logic [DW-1:0] exp_d = '0;

  always #10 clk = ~clk;

  lap_fifo #(.DATA_W(DW), .DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n),
    .push_valid(push_valid), .push_ready(push_ready), .push_data(push_data),
    .pop_ready(pop_ready), .pop_valid(pop_valid), .pop_data(pop_data),
    .pop_data_valid(pop_data_valid),
    .full(full), .empty(empty), .level(level));

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  task automatic compare_all(input string dtag);
    chk(int'(level) == q.size(), "R7", "level", int'(level), q.size());
    chk(empty == (q.size() == 0), "R8", "empty", int'(empty), int'(q.size() == 0));
    chk(full == (q.size() == DEPTH), "R8", "full", int'(full), int'(q.size() == DEPTH));
    chk(pop_valid == (q.size() != 0), "R8", "pop_valid", int'(pop_valid), int'(q.size() != 0));
    chk(pop_data_valid == exp_dv, "R10", "pop_data_valid", int'(pop_data_valid), int'(exp_dv));
    if (exp_dv && pop_data_valid)
      chk(pop_data == exp_d, dtag, "pop_data", int'(pop_data), int'(exp_d));
  endtask

  // Called just after a falling edge; applies inputs over one rising edge.
  task automatic step(input bit pv, input bit pr, input string dtag);
    bit push_ok;
    bit pop_ok;
    push_valid = pv;
    pop_ready  = pr;
    push_data  = DW'($urandom);
    chk(push_ready == (q.size() < DEPTH), "R4", "push_ready",
        int'(push_ready), int'(q.size() < DEPTH));
    push_ok = pv && (q.size() < DEPTH);
    pop_ok  = pr && (q.size() > 0);
    exp_dv  = pop_ok;
    if (pop_ok) exp_d = q.pop_front();
    if (push_ok) q.push_back(push_data);
    @(negedge clk);
    compare_all(dtag);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: act=%0d exp=%0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(empty == 1'b1, "R1", "empty in reset", int'(empty), 1);
    chk(level == 3'd0, "R1", "level in reset", int'(level), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(empty == 1'b1 && full == 1'b0, "R1", "flags after reset", int'({full, empty}), 1);
    chk(pop_data_valid == 1'b0, "R1", "pop_data_valid after reset", int'(pop_data_valid), 0);

    // R5 and R9: pop while empty, then push+pop while empty
    step(1'b0, 1'b1, "R6");
    chk(pop_data_valid == 1'b0, "R5", "pop taken when empty", int'(pop_data_valid), 0);
    step(1'b1, 1'b1, "R6");
    chk(level == 3'd1, "R9", "only push taken when empty", int'(level), 1);

    // R3: fill all six slots
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0, "R6");
    chk(full == 1'b1 && level == 3'd6, "R3", "full after six pushes", int'(level), 6);

    // R4: push while full changes nothing
    step(1'b1, 1'b0, "R6");
    chk(level == 3'd6, "R4", "level after push when full", int'(level), 6);

    // R9: push+pop while full takes only the pop
    step(1'b1, 1'b1, "R6");
    chk(level == 3'd5, "R9", "only pop taken when full", int'(level), 5);

    // R9: simultaneous push+pop in the middle keeps level
    for (int i = 0; i < 4; i++) step(1'b1, 1'b1, "R9");
    chk(level == 3'd5, "R9", "level steady under push+pop", int'(level), 5);

    // drain fully
    for (int i = 0; i < 7; i++) step(1'b0, 1'b1, "R6");

    // R2: steady streaming across many laps
    for (int i = 0; i < 60; i++) step(1'b1, (i > 2), "R2");

    // random traffic with varying bias
    for (int phase = 0; phase < 4; phase++) begin
      for (int i = 0; i < 2000; i++) begin
        int pv_pct;
        int pr_pct;
        pv_pct = (phase == 0) ? 80 : (phase == 1) ? 20 : 50;
        pr_pct = (phase == 0) ? 20 : (phase == 1) ? 80 : 50;
        step(($urandom % 100) < pv_pct, ($urandom % 100) < pr_pct, "R6");
      end
    end

    push_valid = 1'b0;
    pop_ready  = 1'b0;
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule